// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block is a 16-bit up-counter with one PWM channel. The channel output is edge-aligned: it rises when the counter restarts at zero and falls when the counter reaches the compare value. Software reaches the block through a byte-wide register port. The modulo value and the compare value are each written as two bytes. A coherency latch holds the high byte until the matching low byte arrives, so the counter and the channel never see a half-written 16-bit value.

New modulo and compare values are staged. They become active only at the period boundary, where the counter wraps from the modulo value to zero. This applies to a compare value of zero as well, so a duty change never cuts a period short. Clearing the clock-select field stops the counter and freezes the output pin at its present level, even when the channel setup is rewritten. A debug-mode input changes one thing: a write to the timer control register while it is high discards a half-written modulo value.

The channel raises a match flag when the counter reaches the compare value. Software clears the flag in two steps: a read that sees the flag set, then a write of zero to the flag bit.

Top module: `pwm_edge_timer`

## Requirements
- R1: The counter runs only while the clock-select field (address 0, bits [1:0]) is non-zero. In each running cycle it steps by one, and when it equals the active modulo it wraps to 0. With modulo 7 it counts 0,1,…,7,0.
- R2: The channel control register is at address 1, with edge-level bits [1:0], mode bits [3:2] and the flag at bit 7. With mode 2'b10 and edge-level 2'b10 the output is high-true: it is high from count 0 and low from the count equal to the compare value. With modulo 7 and compare 5 it is high for counts 0–4.
- R3: With mode 2'b10 and edge-level bit 0 set, the output is the inverse of the R2 waveform. When mode bit 3 is 0 or the edge-level bits are 00, the output is 0.
- R4: The modulo is written as a high byte at address 2 and a low byte at address 3; the compare is written at addresses 4 (high) and 5 (low). A high-byte write is only buffered. A low-byte write stages the 16-bit value only if a high byte of the same pair is pending. A low-byte write with no pending high byte has no effect.
- R5: A staged value becomes active on the wrap from modulo to 0. A compare change made mid-period, including a change to 0, leaves the current period on the old duty. Addresses 2–5 read back the active value.
- R6: A compare value of 0 gives an output that stays low for the whole period. A compare value greater than the modulo gives an output that stays high.
- R7: While the clock-select field is 00, neither the count nor the output pin changes. This holds even after a channel control write.
- R8: The flag is set on every running cycle whose new count equals the compare value in use. A set in the same cycle as a clear takes priority. The flag is cleared only by a write with bit 7 = 0 that follows a read of address 1 which returned the flag set.
- R9: A write to address 0 while the debug input is high discards a pending modulo high byte, so a following modulo low-byte write is ignored. A pending compare high byte is kept.
- R10: After the active-low reset, clock select, mode and edge-level bits are 00, and the count, the output, the flag and the active modulo and compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte (combinational) |
| dbg_mode | input | 1 | Debug-mode indication |
| cnt_val | output | 16 | Current counter value |
| pwm_out | output | 1 | Channel output pin |
| ch_flag | output | 1 | Raw channel match flag |

## Verification
A register write takes effect at the first rising edge at which the strobe is high. In a running cycle, the count, the output pin and the flag all change at that same edge. A staged modulo or compare value is first used at the wrap edge after it is staged, and a cleared clock select stops the very next edge. A behavioural model in the bench advances on each rising edge from the same inputs. It is compared with the outputs on the falling edge that follows, so every result is checked in the cycle it is due. The directed checks also wait for the count on the falling edge before they judge the output or the flag.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TCTL = 3'd0,
        A_CCTL = 3'd1,
        A_MODH = 3'd2,
        A_MODL = 3'd3,
        A_CMPH = 3'd4,
        A_CMPL = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [1:0] mode;
        logic [1:0] els;
    } ctl_t;
endpackage

// File: rtl/pwm_coh_reg.sv
module pwm_coh_reg #(
    parameter int BYTE_W = 8,
    localparam int W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_part,
    input  logic              load,
    output logic [W-1:0]      act,
    output logic [W-1:0]      nxt
);
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic              pend;
        logic [W-1:0]      stg;
        logic              stg_v;
        logic [W-1:0]      act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        nxt  = st_q.stg_v ? st_q.stg : st_q.act;
        if (load) begin
            st_d.act   = nxt;
            st_d.stg_v = 1'b0;
        end
        if (wr_hi) begin
            st_d.hi   = wdata;
            st_d.pend = 1'b1;
        end else if (wr_lo && st_q.pend) begin
            st_d.stg   = {st_q.hi, wdata};
            st_d.stg_v = 1'b1;
            st_d.pend  = 1'b0;
        end
        if (clr_part) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.act;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] mod_act,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == mod_act);
        if (wrap)      st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign cnt_nx = st_d.cnt;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic [CNT_W-1:0] cmp_nxt,
    input  logic [1:0]       mode,
    input  logic [1:0]       els,
    input  logic             ctl_rd,
    input  logic             ctl_wr,
    input  logic             flag_wbit,
    output logic             pin,
    output logic             flag
);
    typedef struct packed {
        logic raw;
        logic pin;
        logic flag;
        logic arm;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] target;

    always_comb begin
        st_d   = st_q;
        target = wrap ? cmp_nxt : cmp_act;
        if (tick) begin
            if (wrap)                   st_d.raw = (cmp_nxt != '0);
            else if (cnt_nx == cmp_act) st_d.raw = 1'b0;
            st_d.pin = (mode[1] && (els != 2'b00)) ? (st_d.raw ^ els[0]) : 1'b0;
        end
        if (ctl_rd && st_q.flag) st_d.arm = 1'b1;
        if (ctl_wr) begin
            if (st_q.arm && !flag_wbit) st_d.flag = 1'b0;
            st_d.arm = 1'b0;
        end
        if (tick && (cnt_nx == target)) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin  = st_q.pin;
    assign flag = st_q.flag;
endmodule

// File: rtl/pwm_edge_timer.sv
module pwm_edge_timer
    import pwm_tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              dbg_mode,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              pwm_out,
    output logic              ch_flag
);
    ctl_t ctl_d, ctl_q;

    logic             wr_tctl, wr_cctl, rd_cctl;
    logic             tick, wrap;
    logic [CNT_W-1:0] mod_act, mod_nxt, cmp_act, cmp_nxt, cnt_nx;
    logic [1:0]       clk_sel, ch_mode, ch_els;

    assign wr_tctl = bus_wr && (bus_addr == A_TCTL);
    assign wr_cctl = bus_wr && (bus_addr == A_CCTL);
    assign rd_cctl = bus_rd && (bus_addr == A_CCTL);
    assign clk_sel = ctl_q.clk_sel;
    assign ch_mode = ctl_q.mode;
    assign ch_els  = ctl_q.els;
    assign tick    = (ctl_q.clk_sel != 2'b00);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_tctl) ctl_d.clk_sel = bus_wdata[1:0];
        if (wr_cctl) begin
            ctl_d.mode = bus_wdata[3:2];
            ctl_d.els  = bus_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pwm_coh_reg #(.BYTE_W(BYTE_W)) u_mod (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(bus_wr && (bus_addr == A_MODH)),
        .wr_lo(bus_wr && (bus_addr == A_MODL)),
        .wdata(bus_wdata),
        .clr_part(wr_tctl && dbg_mode),
        .load(wrap),
        .act(mod_act), .nxt(mod_nxt)
    );

    pwm_coh_reg #(.BYTE_W(BYTE_W)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(bus_wr && (bus_addr == A_CMPH)),
        .wr_lo(bus_wr && (bus_addr == A_CMPL)),
        .wdata(bus_wdata),
        .clr_part(1'b0),
        .load(wrap),
        .act(cmp_act), .nxt(cmp_nxt)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mod_act(mod_act),
        .cnt(cnt_val), .cnt_nx(cnt_nx), .wrap(wrap)
    );

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap),
        .cnt_nx(cnt_nx), .cmp_act(cmp_act), .cmp_nxt(cmp_nxt),
        .mode(ctl_q.mode), .els(ctl_q.els),
        .ctl_rd(rd_cctl), .ctl_wr(wr_cctl), .flag_wbit(bus_wdata[7]),
        .pin(pwm_out), .flag(ch_flag)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TCTL: bus_rdata = BYTE_W'(ctl_q.clk_sel);
            A_CCTL: bus_rdata = {ch_flag, 3'b000, ctl_q.mode, ctl_q.els};
            A_MODH: bus_rdata = mod_act[CNT_W-1:BYTE_W];
            A_MODL: bus_rdata = mod_act[BYTE_W-1:0];
            A_CMPH: bus_rdata = cmp_act[CNT_W-1:BYTE_W];
            A_CMPL: bus_rdata = cmp_act[BYTE_W-1:0];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_edge_timer_chk.sv
module pwm_edge_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       clk_sel,
    input logic [1:0]       mode,
    input logic [1:0]       els,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mod_act,
    input logic [CNT_W-1:0] cmp_nxt,
    input logic             pin,
    input logic             flag
);
    logic run, at_end;
    assign run    = (clk_sel != 2'b00);
    assign at_end = run && (cnt == mod_act);

    // R1: wrap to zero at the modulo value
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> (cnt == '0));

    // R1: single-step increment below the modulo value
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !at_end) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    // R7: deselected clock freezes count and pin
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> ($stable(cnt) && $stable(pin)));

    // R2: high-true output starts each period high for non-zero compare
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && (cmp_nxt != '0) && mode[1] && (els == 2'b10)) |=> pin);

    // R6: zero compare keeps the high-true output low from the period start
    a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && (cmp_nxt == '0) && mode[1] && (els == 2'b10)) |=> !pin);

    // R8: reaching a zero compare at the wrap raises the flag
    a_r8_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && (cmp_nxt == '0)) |=> flag);
endmodule

bind pwm_edge_timer pwm_edge_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode(ch_mode), .els(ch_els),
    .cnt(cnt_val), .mod_act(mod_act), .cmp_nxt(cmp_nxt),
    .pin(pwm_out), .flag(ch_flag)
);

// File: tb/sim_pwm_edge_timer.sv
module sim_pwm_edge_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, dbg_mode = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cnt_val;
    logic        pwm_out, ch_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pwm_edge_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_mode(dbg_mode), .cnt_val(cnt_val), .pwm_out(pwm_out), .ch_flag(ch_flag)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    int m_sel, m_mode, m_els, m_cnt, m_mod, m_cmp;
    int m_mod_hi, m_cmp_hi, m_mod_new, m_cmp_new;
    bit m_mod_pend, m_cmp_pend, m_mod_has, m_cmp_has;
    bit m_lvl, m_pin, m_flag, m_arm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_mode = 0; m_els = 0; m_cnt = 0; m_mod = 0; m_cmp = 0;
            m_mod_hi = 0; m_cmp_hi = 0; m_mod_new = 0; m_cmp_new = 0;
            m_mod_pend = 0; m_cmp_pend = 0; m_mod_has = 0; m_cmp_has = 0;
            m_lvl = 0; m_pin = 0; m_flag = 0; m_arm = 0;
        end else begin
            bit running, at_end, hit;
            running = (m_sel != 0);
            at_end  = running && (m_cnt == m_mod);
            hit     = 0;
            if (at_end) begin
                if (m_mod_has) m_mod = m_mod_new;
                if (m_cmp_has) m_cmp = m_cmp_new;
                m_mod_has = 0; m_cmp_has = 0;
                m_cnt = 0;
                m_lvl = (m_cmp != 0);
                hit = (m_cmp == 0);
            end else if (running) begin
                m_cnt = (m_cnt + 1) % 65536;
                if (m_cnt == m_cmp) begin m_lvl = 0; hit = 1; end
            end
            if (running)
                m_pin = (m_mode >= 2 && m_els != 0) ? (m_lvl ^ (m_els % 2 == 1)) : 0;
            if (bus_rd && bus_addr == 1 && m_flag) m_arm = 1;
            if (bus_wr && bus_addr == 1) begin
                if (m_arm && !bus_wdata[7]) m_flag = 0;
                m_arm = 0;
            end
            if (hit) m_flag = 1;
            if (bus_wr) begin
                case (bus_addr)
                    0: begin m_sel = bus_wdata & 3; if (dbg_mode) m_mod_pend = 0; end
                    1: begin m_mode = (bus_wdata >> 2) & 3; m_els = bus_wdata & 3; end
                    2: begin m_mod_hi = bus_wdata; m_mod_pend = 1; end
                    3: if (m_mod_pend) begin
                           m_mod_new = m_mod_hi * 256 + bus_wdata; m_mod_has = 1; m_mod_pend = 0;
                       end
                    4: begin m_cmp_hi = bus_wdata; m_cmp_pend = 1; end
                    5: if (m_cmp_pend) begin
                           m_cmp_new = m_cmp_hi * 256 + bus_wdata; m_cmp_has = 1; m_cmp_pend = 0;
                       end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "model count", cnt_val, m_cnt);
            chk("R2", "model pin", pwm_out, m_pin);
            chk("R8", "model flag", ch_flag, m_flag);
        end
    end

    // ---------------- bus helpers ----------------
    task automatic wr(int a, int d);
        bus_wr = 1; bus_addr = a[2:0]; bus_wdata = d[7:0];
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(int a, output int d);
        bus_rd = 1; bus_addr = a[2:0];
        #5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_cnt(int v);
        for (int i = 0; i < 200; i++) begin
            if (cnt_val == v) return;
            @(negedge clk);
        end
    endtask

    task automatic period_start();
        wait_cnt(1);
        wait_cnt(0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        wrap_up();
    end

    // ---------------- directed sequence ----------------
    initial begin
        int d, c0, p0, top;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "count", cnt_val, 0);
        chk("R10", "pin", pwm_out, 0);
        chk("R10", "flag", ch_flag, 0);
        rd(0, d); chk("R10", "clock select", d, 0);
        rd(1, d); chk("R10", "channel control", d, 0);

        // configure modulo 7, compare 5, high-true, then run
        wr(2, 0); wr(3, 7); wr(4, 0); wr(5, 5);
        wr(1, 8'h0A);
        wr(0, 1);
        period_start();
        rd(3, d); chk("R5", "active modulo low", d, 7);
        period_start();
        for (int i = 0; i < 8; i++) begin
            chk("R1", "count sequence", cnt_val, i);
            chk("R2", "high-true level", pwm_out, (cnt_val < 5));
            @(negedge clk);
        end

        // R8: flag set by match, cleared only by read then write 0
        chk("R8", "flag after match", ch_flag, 1);
        wait_cnt(6);
        wr(1, 8'h0A);
        chk("R8", "flag kept without read", ch_flag, 1);
        wait_cnt(0);
        rd(1, d); chk("R8", "flag bit readback", d >> 7, 1);
        wr(1, 8'h0A);
        chk("R8", "flag cleared", ch_flag, 0);

        // R5/R6: mid-period change to zero finishes current period on old duty
        wait_cnt(1);
        wr(4, 0); wr(5, 0);
        wait_cnt(3); chk("R5", "old duty kept count 3", pwm_out, 1);
        @(negedge clk); chk("R5", "old duty kept count 4", pwm_out, 1);
        wait_cnt(5); chk("R5", "old duty falls at 5", pwm_out, 0);
        period_start();
        for (int i = 0; i < 8; i++) begin
            chk("R6", "zero compare low", pwm_out, 0);
            @(negedge clk);
        end

        // R6: compare above modulo gives constant high
        wr(4, 0); wr(5, 9);
        period_start();
        for (int i = 0; i < 8; i++) begin
            chk("R6", "compare above modulo high", pwm_out, 1);
            @(negedge clk);
        end

        // R3: low-true inversion, then disabled output
        wr(4, 0); wr(5, 5);
        wr(1, 8'h09);
        period_start();
        for (int i = 0; i < 8; i++) begin
            chk("R3", "low-true level", pwm_out, (cnt_val >= 5));
            @(negedge clk);
        end
        wr(1, 8'h08);
        @(negedge clk);
        chk("R3", "edge-level 00 output low", pwm_out, 0);
        wr(1, 8'h0A);

        // R4: low byte alone ignored; high then low takes effect
        wr(3, 3);
        period_start();
        period_start();
        rd(3, d); chk("R4", "lone low byte ignored", d, 7);
        wr(2, 0); wr(3, 3);
        period_start();
        period_start();
        rd(3, d); chk("R4", "paired write active", d, 3);
        top = 0;
        for (int i = 0; i < 10; i++) begin
            if (cnt_val > top) top = cnt_val;
            @(negedge clk);
        end
        chk("R4", "new modulo peak count", top, 3);

        // R9: debug control write drops modulo high byte but keeps compare high byte
        wr(2, 0); wr(4, 0);
        dbg_mode = 1;
        wr(0, 1);
        dbg_mode = 0;
        wr(3, 5); wr(5, 2);
        period_start();
        period_start();
        rd(3, d); chk("R9", "modulo low write dropped", d, 3);
        rd(5, d); chk("R9", "compare latch kept", d, 2);

        // R7: clock deselected freezes count and pin, even after channel write
        wr(0, 0);
        @(negedge clk);
        c0 = cnt_val; p0 = pwm_out;
        wr(1, 8'h09);
        repeat (5) @(negedge clk);
        chk("R7", "count frozen", cnt_val, c0);
        chk("R7", "pin frozen", pwm_out, p0);
        wr(0, 1);
        repeat (10) @(negedge clk);

        wrap_up();
    end
endmodule